// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment:offset pair into a 20-bit byte address for a processor's bus unit. It holds four segment registers (code, data, stack, extra) together with the instruction pointer and the stack pointer. The access type picks both the segment and the offset. The caller never names a segment. Instruction fetches use the code segment and the instruction pointer. Data accesses use the data segment and the supplied effective address. String destinations use the extra segment and the supplied destination index. Stack pushes and pops use the stack segment and the stack pointer.

The physical address and the number of byte bus cycles are combinational functions of the current registers and the request inputs. When `req_valid` is high at a rising clock edge, the implicit pointer updates happen:
- a fetch advances the instruction pointer by the bytes fetched;
- a push lowers the stack pointer by two, and the push address already uses the lowered value;
- a pop raises the stack pointer by two after the address is formed.

A register write port loads any of the six registers, so decode logic can set up the pointers.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals the selected segment value times 16 plus the selected 16-bit offset.
- R2: The sum wraps modulo 2^20, so for example segment FFFFh with offset FFFFh gives 0FFEFh.
- R3: Request kind 0 (fetch) selects the code segment with the instruction pointer as offset.
- R4: Request kind 1 (data) selects the data segment with `req_ea` as offset. The unused kinds 5, 6 and 7 behave the same way.
- R5: Request kind 4 (string destination) selects the extra segment with `req_ea` as offset.
- R6: Request kind 2 (push) addresses stack segment : (SP-2). When issued, SP becomes SP-2.
- R7: Request kind 3 (pop) addresses stack segment : SP. When issued, SP becomes SP+2.
- R8: The stack pointer wraps within 16 bits, in both directions. For example, a push with SP=0000h addresses offset FFFEh.
- R9: `bus_cycles` behaves as follows:
  - it is 1 for a byte access (`req_word`=0);
  - it is 1 for a word at an even physical address;
  - it is 2 for a word at an odd physical address;
  - push and pop always count as word accesses.
- R10: An issued fetch advances the instruction pointer by 1 (byte) or 2 (word). The pointer wraps at 16 bits and the code segment stays unchanged.
- R11: The write port loads a register on the next rising edge. The `wr_sel` codes are 0 code, 1 data, 2 stack, 3 extra, 4 instruction pointer and 5 stack pointer. A write overrides a same-cycle pointer update of that register. Codes 6 and 7 change nothing.
- R12: After reset all six registers are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Commits the pointer update of the current request at the edge |
| req_kind | input | 3 | Access type: 0 fetch, 1 data, 2 push, 3 pop, 4 string destination |
| req_word | input | 1 | 1 for a 16-bit access, 0 for a byte |
| req_ea | input | 16 | Effective address or destination index offset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 16 | Write value |
| phys_addr | output | 20 | Physical byte address of the request |
| bus_cycles | output | 2 | Byte bus cycles the request needs (1 or 2) |

## Verification
The hardest situations to reach are the ones where two updates or two wraps meet in one cycle. One is a register write that lands on the same edge as a push or a fetch on that register. The other is a pointer that steps across its 16-bit boundary while the 20-bit sum also crosses the top of memory. The stimulus loads the pointers to values next to each boundary, such as SP=0000h, SP=FFFEh and IP=FFFFh. It then issues the stepping request, including one deliberate collision with the write port, and reads the result back at the ports through a following fetch or pop probe. A sweep over sixteen segment values and sixteen offsets covers the adder carry into the top nibble and both address parities.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  // request kinds
  localparam logic [2:0] KIND_FETCH  = 3'd0;
  localparam logic [2:0] KIND_DATA   = 3'd1;
  localparam logic [2:0] KIND_PUSH   = 3'd2;
  localparam logic [2:0] KIND_POP    = 3'd3;
  localparam logic [2:0] KIND_STRDST = 3'd4;

  // register write codes
  localparam logic [2:0] REG_CS = 3'd0;
  localparam logic [2:0] REG_DS = 3'd1;
  localparam logic [2:0] REG_SS = 3'd2;
  localparam logic [2:0] REG_ES = 3'd3;
  localparam logic [2:0] REG_IP = 3'd4;
  localparam logic [2:0] REG_SP = 3'd5;

  localparam int NUM_REGS   = 6;
  localparam int STACK_STEP = 2;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              ip_adv,
  input  logic [1:0]        ip_bytes,
  input  logic              sp_down,
  input  logic              sp_up,
  output logic [WORD_W-1:0] cs_o,
  output logic [WORD_W-1:0] ds_o,
  output logic [WORD_W-1:0] ss_o,
  output logic [WORD_W-1:0] es_o,
  output logic [WORD_W-1:0] ip_o,
  output logic [WORD_W-1:0] sp_o
);

  logic [WORD_W-1:0] regs_v [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam bit IS_IP = (g == int'(REG_IP));
    localparam bit IS_SP = (g == int'(REG_SP));
    logic [WORD_W-1:0] q;
    logic [WORD_W-1:0] d;

    always_comb begin
      d = q;
      if (IS_IP && ip_adv)  d = q + WORD_W'(ip_bytes);
      if (IS_SP && sp_down) d = q - WORD_W'(STACK_STEP);
      if (IS_SP && sp_up)   d = q + WORD_W'(STACK_STEP);
      // the write port has the last word
      if (wr_en && (wr_sel == 3'(g))) d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign regs_v[g] = q;
  end

  assign cs_o = regs_v[REG_CS];
  assign ds_o = regs_v[REG_DS];
  assign ss_o = regs_v[REG_SS];
  assign es_o = regs_v[REG_ES];
  assign ip_o = regs_v[REG_IP];
  assign sp_o = regs_v[REG_SP];

endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [2:0]        kind,
  input  logic [WORD_W-1:0] ea,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] ds_i,
  input  logic [WORD_W-1:0] ss_i,
  input  logic [WORD_W-1:0] es_i,
  input  logic [WORD_W-1:0] ip_i,
  input  logic [WORD_W-1:0] sp_i,
  output logic [WORD_W-1:0] seg_o,
  output logic [WORD_W-1:0] off_o,
  output logic              is_fetch,
  output logic              is_push,
  output logic              is_pop
);

  logic [WORD_W-1:0] sp_pre;
  assign sp_pre = sp_i - WORD_W'(STACK_STEP);

  always_comb begin
    is_fetch = 1'b0;
    is_push  = 1'b0;
    is_pop   = 1'b0;
    seg_o    = ds_i;
    off_o    = ea;
    case (kind)
      KIND_FETCH: begin
        is_fetch = 1'b1;
        seg_o    = cs_i;
        off_o    = ip_i;
      end
      KIND_PUSH: begin
        is_push = 1'b1;
        seg_o   = ss_i;
        off_o   = sp_pre;
      end
      KIND_POP: begin
        is_pop = 1'b1;
        seg_o  = ss_i;
        off_o  = sp_i;
      end
      KIND_STRDST: begin
        seg_o = es_i;
        off_o = ea;
      end
      default: begin
        seg_o = ds_i;
        off_o = ea;
      end
    endcase
  end

endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
  parameter int WORD_W    = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic [WORD_W-1:0]           seg_i,
  input  logic [WORD_W-1:0]           off_i,
  input  logic                        word_i,
  output logic [WORD_W+SEG_SHIFT-1:0] phys_o,
  output logic                        odd_word_o,
  output logic [1:0]                  cycles_o
);

  localparam int ADDR_W = WORD_W + SEG_SHIFT;

  function automatic logic [ADDR_W-1:0] form_phys(
    input logic [WORD_W-1:0] s,
    input logic [WORD_W-1:0] o
  );
    return {s, {SEG_SHIFT{1'b0}}} + ADDR_W'(o);
  endfunction

  function automatic logic [1:0] count_cycles(input logic word, input logic lsb);
    return (word && lsb) ? 2'd2 : 2'd1;
  endfunction

  assign phys_o     = form_phys(seg_i, off_i);
  assign odd_word_o = word_i & phys_o[0];
  assign cycles_o   = count_cycles(word_i, phys_o[0]);

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [2:0]                  req_kind,
  input  logic                        req_word,
  input  logic [WORD_W-1:0]           req_ea,
  input  logic                        wr_en,
  input  logic [2:0]                  wr_sel,
  input  logic [WORD_W-1:0]           wr_data,
  output logic [WORD_W+SEG_SHIFT-1:0] phys_addr,
  output logic [1:0]                  bus_cycles
);

  localparam int ADDR_W = WORD_W + SEG_SHIFT;

  logic [WORD_W-1:0] cs_q, ds_q, ss_q, es_q, ip_q, sp_q;
  logic [WORD_W-1:0] sel_seg, sel_off;
  logic              is_fetch, is_push, is_pop;
  logic              word_eff;
  logic              odd_word;
  logic [ADDR_W-1:0] phys_w;
  logic [1:0]        cycles_w;

  // named events for the checker
  logic              ip_adv, sp_down, sp_up;
  logic [1:0]        ip_bytes;

  assign word_eff = req_word | is_push | is_pop;
  assign ip_adv   = req_valid & is_fetch;
  assign sp_down  = req_valid & is_push;
  assign sp_up    = req_valid & is_pop;
  assign ip_bytes = word_eff ? 2'd2 : 2'd1;

  seg_regfile #(.WORD_W(WORD_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .ip_adv   (ip_adv),
    .ip_bytes (ip_bytes),
    .sp_down  (sp_down),
    .sp_up    (sp_up),
    .cs_o     (cs_q),
    .ds_o     (ds_q),
    .ss_o     (ss_q),
    .es_o     (es_q),
    .ip_o     (ip_q),
    .sp_o     (sp_q)
  );

  seg_select #(.WORD_W(WORD_W)) u_sel (
    .kind     (req_kind),
    .ea       (req_ea),
    .cs_i     (cs_q),
    .ds_i     (ds_q),
    .ss_i     (ss_q),
    .es_i     (es_q),
    .ip_i     (ip_q),
    .sp_i     (sp_q),
    .seg_o    (sel_seg),
    .off_o    (sel_off),
    .is_fetch (is_fetch),
    .is_push  (is_push),
    .is_pop   (is_pop)
  );

  seg_adder #(.WORD_W(WORD_W), .SEG_SHIFT(SEG_SHIFT)) u_add (
    .seg_i      (sel_seg),
    .off_i      (sel_off),
    .word_i     (word_eff),
    .phys_o     (phys_w),
    .odd_word_o (odd_word),
    .cycles_o   (cycles_w)
  );

  assign phys_addr  = phys_w;
  assign bus_cycles = cycles_w;

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk
  import seg_addr_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int SEG_SHIFT = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic [2:0]                  req_kind,
  input logic                        req_word,
  input logic                        wr_en,
  input logic [2:0]                  wr_sel,
  input logic [WORD_W-1:0]           wr_data,
  input logic [WORD_W+SEG_SHIFT-1:0] phys_addr,
  input logic [1:0]                  bus_cycles,
  input logic [WORD_W-1:0]           cs_q,
  input logic [WORD_W-1:0]           ip_q,
  input logic [WORD_W-1:0]           sp_q,
  input logic                        word_eff,
  input logic                        odd_word
);

  logic push_go, pop_go, fetch_go, sp_wr, ip_wr, cs_wr;
  assign push_go  = req_valid && (req_kind == KIND_PUSH);
  assign pop_go   = req_valid && (req_kind == KIND_POP);
  assign fetch_go = req_valid && (req_kind == KIND_FETCH);
  assign sp_wr    = wr_en && (wr_sel == REG_SP);
  assign ip_wr    = wr_en && (wr_sel == REG_IP);
  assign cs_wr    = wr_en && (wr_sel == REG_CS);

  assert_push_predec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_go && !sp_wr) |=> (sp_q == $past(sp_q) - WORD_W'(STACK_STEP)));

  assert_pop_postinc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_go && !sp_wr) |=> (sp_q == $past(sp_q) + WORD_W'(STACK_STEP)));

  assert_ip_advance_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_go && !ip_wr) |=>
      (ip_q == $past(ip_q) + ($past(req_word) ? WORD_W'(2) : WORD_W'(1))));

  assert_cs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_go && !cs_wr) |=> $stable(cs_q));

  assert_byte_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !word_eff |-> (bus_cycles == 2'd1));

  assert_odd_word_split_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_eff && phys_addr[0]) |-> (bus_cycles == 2'd2 && odd_word));

  assert_sp_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr |=> (sp_q == $past(wr_data)));

  assert_ip_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ip_wr |=> (ip_q == $past(wr_data)));

endmodule

bind seg_addr_gen seg_addr_gen_chk #(.WORD_W(WORD_W), .SEG_SHIFT(SEG_SHIFT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_kind   (req_kind),
  .req_word   (req_word),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .phys_addr  (phys_addr),
  .bus_cycles (bus_cycles),
  .cs_q       (cs_q),
  .ip_q       (ip_q),
  .sp_q       (sp_q),
  .word_eff   (word_eff),
  .odd_word   (odd_word)
);

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic        req_word = 1'b0;
  logic [15:0] req_ea = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [15:0] wr_data = '0;
  logic [19:0] phys_addr;
  logic [1:0]  bus_cycles;

  int total = 0;
  int bad = 0;
  logic [19:0] got_a;
  logic [1:0]  got_c;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_word(req_word), .req_ea(req_ea), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .phys_addr(phys_addr), .bus_cycles(bus_cycles)
  );

  function automatic int exp_phys(input int seg, input int off);
    return (seg * 16 + off) % 1048576;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setreg(input logic [2:0] sel, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [2:0] k, input logic w, input logic [15:0] ea);
    @(negedge clk);
    req_valid = 1'b0; req_kind = k; req_word = w; req_ea = ea;
    #1;
    got_a = phys_addr; got_c = bus_cycles;
  endtask

  task automatic issue(input logic [2:0] k, input logic w, input logic [15:0] ea);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_word = w; req_ea = ea;
    #1;
    got_a = phys_addr; got_c = bus_cycles;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    look(3'd0, 1'b1, 16'h0);
    check("R12 fetch addr", int'(got_a), 0);
    check("R12 fetch cycles", int'(got_c), 1);
    look(3'd1, 1'b0, 16'h1234);
    check("R12 data addr", int'(got_a), 'h01234);
    look(3'd2, 1'b1, 16'h0);
    check("R12 R8 push at sp0", int'(got_a), 'h0FFFE);

    // R1 R2 R4 R9 sweep over data segment and offsets
    for (int i = 0; i < 16; i++) begin
      int seg;
      seg = i * 'h1111;
      setreg(3'd1, 16'(seg));
      for (int j = 0; j < 16; j++) begin
        int off;
        off = (j * 'h1111) & 'hFFFF;
        look(3'd1, 1'b1, 16'(off));
        check("R1 R2 R4 data addr", int'(got_a), exp_phys(seg, off));
        check("R9 word cycles", int'(got_c), (off % 2 == 1) ? 2 : 1);
        look(3'd1, 1'b0, 16'(off));
        check("R9 byte cycles", int'(got_c), 1);
      end
    end
    setreg(3'd1, 16'hFFFF);
    look(3'd1, 1'b1, 16'hFFFF);
    check("R2 wrap top", int'(got_a), 'h0FFEF);

    // R5 and R4 unused kinds
    setreg(3'd3, 16'hA4FB);
    setreg(3'd1, 16'h1000);
    look(3'd4, 1'b1, 16'h4872);
    check("R5 string dest", int'(got_a), 'hA9822);
    look(3'd1, 1'b1, 16'h4872);
    check("R4 data seg", int'(got_a), 'h14872);
    for (int k = 5; k < 8; k++) begin
      look(3'(k), 1'b0, 16'h0029);
      check("R4 unused kind as data", int'(got_a), 'h10029);
    end

    // R3 R10 fetch
    setreg(3'd0, 16'h0400);
    setreg(3'd4, 16'h0056);
    issue(3'd0, 1'b1, 16'h0);
    check("R3 fetch addr", int'(got_a), 'h04056);
    look(3'd0, 1'b0, 16'h0);
    check("R10 ip +2", int'(got_a), 'h04058);
    issue(3'd0, 1'b0, 16'h0);
    look(3'd0, 1'b1, 16'h0);
    check("R10 ip +1", int'(got_a), 'h04059);
    check("R9 odd word fetch", int'(got_c), 2);
    issue(3'd0, 1'b1, 16'h0);
    look(3'd0, 1'b0, 16'h0);
    check("R10 ip after odd word", int'(got_a), 'h0405B);
    setreg(3'd4, 16'hFFFF);
    issue(3'd0, 1'b0, 16'h0);
    check("R10 fetch at ip top", int'(got_a), 'h13FFF);
    look(3'd0, 1'b0, 16'h0);
    check("R10 ip wrap cs kept", int'(got_a), 'h04000);

    // R6 R7 stack
    setreg(3'd2, 16'h0A00);
    setreg(3'd5, 16'h0100);
    look(3'd2, 1'b1, 16'h0);
    check("R6 push probe", int'(got_a), 'h0A0FE);
    issue(3'd2, 1'b1, 16'h0);
    check("R6 push1", int'(got_a), 'h0A0FE);
    issue(3'd2, 1'b0, 16'h0);
    check("R6 push2", int'(got_a), 'h0A0FC);
    check("R9 stack even", int'(got_c), 1);
    issue(3'd3, 1'b1, 16'h0);
    check("R7 pop1", int'(got_a), 'h0A0FC);
    issue(3'd3, 1'b1, 16'h0);
    check("R7 pop2", int'(got_a), 'h0A0FE);
    look(3'd3, 1'b1, 16'h0);
    check("R7 pop probe", int'(got_a), 'h0A100);
    setreg(3'd5, 16'h0101);
    look(3'd2, 1'b0, 16'h0);
    check("R9 stack forced word odd", int'(got_c), 2);
    check("R6 odd sp addr", int'(got_a), 'h0A0FF);

    // R8 wraps
    setreg(3'd5, 16'h0000);
    issue(3'd2, 1'b1, 16'h0);
    check("R8 push wrap", int'(got_a), 'h19FFE);
    issue(3'd3, 1'b1, 16'h0);
    check("R8 pop at FFFE", int'(got_a), 'h19FFE);
    look(3'd3, 1'b1, 16'h0);
    check("R8 pop wrap to 0", int'(got_a), 'h0A000);

    // R11 collisions and ignored codes
    setreg(3'd5, 16'h0100);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd2; req_word = 1'b1;
    wr_en = 1'b1; wr_sel = 3'd5; wr_data = 16'h0200;
    @(posedge clk);
    #1;
    req_valid = 1'b0; wr_en = 1'b0;
    look(3'd3, 1'b1, 16'h0);
    check("R11 sp write beats push", int'(got_a), 'h0A200);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd0; req_word = 1'b1;
    wr_en = 1'b1; wr_sel = 3'd4; wr_data = 16'h1000;
    @(posedge clk);
    #1;
    req_valid = 1'b0; wr_en = 1'b0;
    look(3'd0, 1'b1, 16'h0);
    check("R11 ip write beats fetch", int'(got_a), 'h05000);
    setreg(3'd6, 16'h5555);
    setreg(3'd7, 16'h7777);
    look(3'd0, 1'b1, 16'h0);
    check("R11 code 6/7 ignored fetch", int'(got_a), 'h05000);
    look(3'd1, 1'b1, 16'h0);
    check("R11 code 6/7 ignored data", int'(got_a), 'h10000);
    look(3'd4, 1'b1, 16'h0);
    check("R11 code 6/7 ignored extra", int'(got_a), 'hA4FB0);
    look(3'd3, 1'b1, 16'h0);
    check("R11 code 6/7 ignored stack", int'(got_a), 'h0A200);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule